// File: doc/BRIEF.md
# Symbol Clock Recovery With NRZI Decoder

This block turns an oversampled one-bit symbol stream into decoded data bits. A signed phase accumulator moves forward by a fixed step on every sample strobe, so that it wraps from positive to negative once per symbol period. The wrap marks the sampling instant. Each time the two newest raw symbols differ, the accumulator is scaled toward zero, which pulls the wrap to the middle of the symbol. A stronger pull is used while the carrier-detect input reports no lock, and a gentler one once it does.

At the sampling instant, the three newest raw symbols are combined by majority vote. The voted symbol can be passed through a self-synchronizing descrambler. It is then compared with the previous synchronized symbol to give an NRZI-decoded bit, which is presented together with a one-clock valid pulse. A mode input selects the oversampling ratio and the locked pull strength. Three speed classes are supported. Deframing and unstuffing are left to the consumer of the bit stream.

Top module: `bitSyncNrzi`

## Requirements
- R1: On each clock with `sampleStb` high, the 32-bit signed accumulator gains 2^32/N, with wrap-around. Without a strobe, the accumulator, the raw history, the descrambler and the outputs hold, whatever `rawSym` does. After reset the accumulator is 0, so the first sampling instant falls on strobe number N/2.
- R2: A sampling instant is a strobe on which the advanced accumulator is negative and its previous value is strictly positive. `bitValid` is high in the clock after such a strobe's edge and in no other clock.
- R3: The symbol taken at a sampling instant is the majority of the current `rawSym` and the two raw symbols from the preceding strobes: two or three ones give 1.
- R4: The decoded bit is 1 when the synchronized symbol equals the previous synchronized symbol, and 0 when they differ. The previous synchronized symbol is 0 after reset.
- R5: With `descrEn` high, the synchronized symbol is vote XOR state bit 16 XOR state bit 11. The 17-bit state then shifts left by one and takes the voted symbol into bit 0. The state is all ones after reset. It changes only at sampling instants with `descrEn` high.
- R6: When `rawSym` differs from the raw symbol of the previous strobe, the accumulator is first advanced and then multiplied by a tune factor of F/65536. The product is truncated toward zero.
- R7: `modeSel` encoding: 0 gives N=8, 1 gives N=32, 2 gives N=4, and 3 behaves as 0. The locked factor F is 48497 (about 0.74) in modes 0, 1 and 3, and 58327 (about 0.89) in mode 2. When `dcdIn` is low, F is 32768 (0.5) in every mode.
- R8: `bitValid` is never high on two consecutive clocks. `bitOut` changes only together with `bitValid` and holds between pulses.
- R9: While `rstN` is low, `bitValid` and `bitOut` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStb | input | 1 | One oversampled symbol is present on this clock |
| rawSym | input | 1 | Raw demodulated symbol, qualified by sampleStb |
| dcdIn | input | 1 | Carrier detect, used as the lock indicator |
| modeSel | input | 2 | Speed class: 0 / 3 eight-fold, 1 thirty-two-fold, 2 four-fold |
| descrEn | input | 1 | Pass the voted symbol through the descrambler |
| bitOut | output | 1 | NRZI-decoded data bit |
| bitValid | output | 1 | One-clock pulse marking a new bitOut |

## Verification
A wrong accumulator value first shows at the ports as a sampling instant that comes one or more strobes early or late. That error is visible at the next `bitValid` pulse, within one symbol period. A wrong raw history or a wrong vote flips `bitOut` on the same pulse. Both the decoded bit and the following NRZI comparison go wrong. A corrupted descrambler state is worse: it flips `bitOut` on every pulse where tap 16 or tap 11 is wrong, and it stays wrong for up to 17 sampling instants until the bad bits have shifted out. The bench compares both outputs against a behavioural model on every clock, so each of these faults is caught within a single symbol period.

// File: rtl/bcrPkg.sv
package bcrPkg;

  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_SLOW = 2'd1,
    MODE_FAST = 2'd2,
    MODE_ALT  = 2'd3
  } bcrMode_e;

  // strobes handed from the phase control to the bit datapath
  typedef struct packed {
    logic shiftRaw;   // a new raw symbol is accepted this clock
    logic sampleNow;  // this strobe is a sampling instant
  } bcrStb_t;

endpackage

// File: rtl/bcrPhaseCtl.sv
module bcrPhaseCtl
  import bcrPkg::*;
#(
  parameter int ACC_W        = 32,
  parameter int FRAC_W       = 16,
  parameter int N_STD        = 8,
  parameter int N_SLOW       = 32,
  parameter int N_FAST       = 4,
  parameter int TUNE_LOCK    = 48497,
  parameter int TUNE_LOCK_HI = 58327,
  parameter int TUNE_FREE    = 32768
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sampleStb,
  input  logic           rawEdge,
  input  logic           dcdIn,
  input  logic [1:0]     modeSel,
  output bcrStb_t        stb
);

  localparam int PROD_W = ACC_W + FRAC_W + 1;
  localparam logic [ACC_W-1:0] STEP_STD  = ACC_W'((64'd1 << ACC_W) / N_STD);
  localparam logic [ACC_W-1:0] STEP_SLOW = ACC_W'((64'd1 << ACC_W) / N_SLOW);
  localparam logic [ACC_W-1:0] STEP_FAST = ACC_W'((64'd1 << ACC_W) / N_FAST);
  localparam logic [FRAC_W:0] F_LOCK    = (FRAC_W+1)'(TUNE_LOCK);
  localparam logic [FRAC_W:0] F_LOCK_HI = (FRAC_W+1)'(TUNE_LOCK_HI);
  localparam logic [FRAC_W:0] F_FREE    = (FRAC_W+1)'(TUNE_FREE);
  localparam logic signed [PROD_W-1:0] ROUND_BIAS = PROD_W'((64'd1 << FRAC_W) - 1);

  bcrMode_e mode;
  logic signed [ACC_W-1:0] accQ, accAdv, accTuned;
  logic [ACC_W-1:0] step;
  logic [FRAC_W:0] tune;
  logic signed [PROD_W-1:0] prod, biased;
  logic instant;

  assign mode = bcrMode_e'(modeSel);

  always_comb begin
    case (mode)
      MODE_SLOW: step = STEP_SLOW;
      MODE_FAST: step = STEP_FAST;
      default:   step = STEP_STD;
    endcase
  end

  always_comb begin
    if (!dcdIn)                 tune = F_FREE;
    else if (mode == MODE_FAST) tune = F_LOCK_HI;
    else                        tune = F_LOCK;
  end

  // advance first, then test for the positive-to-negative wrap
  assign accAdv  = accQ + $signed(step);
  assign instant = accAdv[ACC_W-1] && !accQ[ACC_W-1] && (accQ != '0);

  // scale the advanced phase; bias negative products so the shift truncates toward zero
  assign prod     = PROD_W'(accAdv) * $signed({1'b0, tune});
  assign biased   = prod[PROD_W-1] ? prod + ROUND_BIAS : prod;
  assign accTuned = ACC_W'(biased >>> FRAC_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (sampleStb) begin
      accQ <= rawEdge ? accTuned : accAdv;
    end
  end

  assign stb.shiftRaw  = sampleStb;
  assign stb.sampleNow = sampleStb && instant;

endmodule

// File: rtl/bcrBitPath.sv
module bcrBitPath
  import bcrPkg::*;
#(
  parameter int VOTE_LEN = 3,
  parameter int TAP_HI   = 16,
  parameter int TAP_LO   = 11
) (
  input  logic    clk,
  input  logic    rstN,
  input  bcrStb_t stb,
  input  logic    rawSym,
  input  logic    descrEn,
  output logic    rawEdge,
  output logic    bitOut,
  output logic    bitValid
);

  localparam int HIST_W = VOTE_LEN - 1;
  localparam int SCR_W  = TAP_HI + 1;

  logic [HIST_W-1:0] rawQ;
  logic [VOTE_LEN-1:0] voteWin;
  logic [SCR_W-1:0] scrQ;
  logic vote, descrOut, symSync, syncQ;

  generate
    if (HIST_W == 1) begin : g_win1
      assign voteWin = {rawQ, rawSym};
    end else begin : g_winN
      assign voteWin = {rawQ[HIST_W-1:0], rawSym};
    end
  endgenerate

  assign rawEdge  = rawQ[0] ^ rawSym;
  assign vote     = ($countones(voteWin) > VOTE_LEN / 2);
  assign descrOut = vote ^ scrQ[TAP_HI] ^ scrQ[TAP_LO];
  assign symSync  = descrEn ? descrOut : vote;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ     <= '0;
      scrQ     <= '1;
      syncQ    <= 1'b0;
      bitOut   <= 1'b0;
      bitValid <= 1'b0;
    end else begin
      bitValid <= stb.sampleNow;
      if (stb.shiftRaw) begin
        rawQ <= voteWin[HIST_W-1:0];
      end
      if (stb.sampleNow) begin
        syncQ  <= symSync;
        bitOut <= ~(syncQ ^ symSync);
        if (descrEn) begin
          scrQ <= {scrQ[SCR_W-2:0], vote};
        end
      end
    end
  end

endmodule

// File: rtl/bitSyncNrzi.sv
module bitSyncNrzi
  import bcrPkg::*;
#(
  parameter int ACC_W        = 32,
  parameter int FRAC_W       = 16,
  parameter int N_STD        = 8,
  parameter int N_SLOW       = 32,
  parameter int N_FAST       = 4,
  parameter int TUNE_LOCK    = 48497,
  parameter int TUNE_LOCK_HI = 58327,
  parameter int TUNE_FREE    = 32768,
  parameter int VOTE_LEN     = 3,
  parameter int TAP_HI       = 16,
  parameter int TAP_LO       = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleStb,
  input  logic       rawSym,
  input  logic       dcdIn,
  input  logic [1:0] modeSel,
  input  logic       descrEn,
  output logic       bitOut,
  output logic       bitValid
);

  bcrStb_t stb;
  logic rawEdge;

  bcrPhaseCtl #(
    .ACC_W(ACC_W), .FRAC_W(FRAC_W),
    .N_STD(N_STD), .N_SLOW(N_SLOW), .N_FAST(N_FAST),
    .TUNE_LOCK(TUNE_LOCK), .TUNE_LOCK_HI(TUNE_LOCK_HI), .TUNE_FREE(TUNE_FREE)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .rawEdge(rawEdge),
    .dcdIn(dcdIn), .modeSel(modeSel), .stb(stb)
  );

  bcrBitPath #(
    .VOTE_LEN(VOTE_LEN), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)
  ) path_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rawSym(rawSym), .descrEn(descrEn),
    .rawEdge(rawEdge), .bitOut(bitOut), .bitValid(bitValid)
  );

endmodule

// File: rtl/bitSyncNrziChk.sv
module bitSyncNrziChk (
  input logic clk,
  input logic rstN,
  input logic sampleStb,
  input logic bitOut,
  input logic bitValid
);

  // R8: the valid pulse lasts a single clock
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  // R2: a valid pulse always follows a strobe
  a_r2_valid_after_stb: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> !bitValid);

  // R8: the data bit moves only together with a valid pulse
  a_r8_bit_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bitOut) |-> bitValid);

  // R1: without a strobe, nothing new is produced on the next clock
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleStb && !bitValid) |=> $stable(bitOut));

endmodule

bind bitSyncNrzi bitSyncNrziChk chk_i (
  .clk(clk), .rstN(rstN), .sampleStb(sampleStb),
  .bitOut(bitOut), .bitValid(bitValid)
);

// File: tb/bitSyncNrzi_tb_top.sv
module bitSyncNrzi_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 1'b0;
  logic rawSym = 1'b0;
  logic dcdIn = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic descrEn = 1'b0;
  logic bitOut, bitValid;

  int checks = 0;
  int errors = 0;
  string tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  bitSyncNrzi dut_i (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .rawSym(rawSym),
    .dcdIn(dcdIn), .modeSel(modeSel), .descrEn(descrEn),
    .bitOut(bitOut), .bitValid(bitValid)
  );

  // ---------------- behavioural reference model ----------------
  int mAcc;
  bit mRaw[$];
  int unsigned mScr;
  bit mSync, expBit, expValid;

  function automatic int ovs(input logic [1:0] m);
    case (m)
      2'd1: return 32;
      2'd2: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic longint factor(input logic [1:0] m, input bit lock);
    if (!lock) return 32768;
    if (m == 2'd2) return 58327;
    return 48497;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAcc = 0; mRaw = '{0, 0, 0}; mScr = 32'h1FFFF;
      mSync = 0; expBit = 0; expValid = 0;
    end else if (!sampleStb) begin
      expValid = 0;
    end else begin
      int prev, nxt, ones;
      bit v, d;
      prev = mAcc;
      nxt  = mAcc + int'((64'd1 << 32) / ovs(modeSel));
      mRaw.push_front(rawSym);
      void'(mRaw.pop_back());
      expValid = 0;
      if (nxt < 0 && prev > 0) begin
        ones = int'(mRaw[0]) + int'(mRaw[1]) + int'(mRaw[2]);
        v = (ones >= 2);
        d = v;
        if (descrEn) begin
          d = v ^ mScr[16] ^ mScr[11];
          mScr = ((mScr << 1) | v) & 32'h1FFFF;
        end
        expBit = (d == mSync);
        mSync = d;
        expValid = 1;
      end
      if (mRaw[0] != mRaw[1])
        mAcc = int'((longint'(nxt) * factor(modeSel, dcdIn)) / 64'sd65536);
      else
        mAcc = nxt;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // one clock: model and DUT update at the edge, both outputs compared after it
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check(tag, "bitValid", int'(bitValid), int'(expValid));
    check(tag, "bitOut", int'(bitOut), int'(expBit));
  endtask

  task automatic doReset();
    rstN = 1'b0; sampleStb = 0; rawSym = 0;
    repeat (2) @(negedge clk);
    check("R9", "bitValid in reset", int'(bitValid), 0);
    check("R9", "bitOut in reset", int'(bitOut), 0);
    rstN = 1'b1;
  endtask

  // R1/R7: count strobes until the first valid pulse with a steady input
  task automatic firstInstant(input logic [1:0] m, input int expN);
    int n = 0;
    modeSel = m; dcdIn = 0; descrEn = 0;
    doReset();
    tag = "R1";
    sampleStb = 1; rawSym = 0;
    while (n < 64) begin
      n++;
      tick();
      if (bitValid) break;
    end
    check("R7", "strobes to first instant", n, expN);
  endtask

  // symbol stream held for about N strobes per symbol, optional glitches and idle gaps
  task automatic runStream(input string req, input logic [1:0] m, input bit dcd,
                           input bit scr, input bit glitch, input bit gaps,
                           input int nStb, input int symLen);
    bit data = 0;
    int phase = 0;
    int pulses = 0;
    tag = req; modeSel = m; dcdIn = dcd; descrEn = scr;
    for (int i = 0; i < nStb; i++) begin
      if (phase == 0) data = $urandom_range(0, 1);
      phase = (phase + 1) % symLen;
      sampleStb = 1;
      rawSym = (glitch && ($urandom_range(0, 9) == 0)) ? ~data : data;
      tick();
      if (bitValid) pulses++;
      if (gaps) begin
        // R1: raw symbols presented without a strobe must be ignored
        sampleStb = 0;
        for (int g = 0; g < 2; g++) begin
          rawSym = $urandom_range(0, 1);
          tick();
        end
      end
    end
    sampleStb = 0;
    check(req, "pulses seen", (pulses > nStb / (2 * symLen)) ? 1 : 0, 1);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    doReset();
    tick();

    firstInstant(2'd0, 4);
    firstInstant(2'd1, 16);
    firstInstant(2'd2, 2);
    firstInstant(2'd3, 4);

    // R4: steady ones input, no transitions: every decoded bit after the first is 1
    modeSel = 2'd0; doReset();
    begin
      int ones = 0;
      int seen = 0;
      tag = "R4"; sampleStb = 1; rawSym = 1;
      for (int i = 0; i < 80; i++) begin
        tick();
        if (bitValid) begin seen++; if (bitOut) ones++; end
      end
      check("R4", "first bit 0 then ones", ones, seen - 1);
    end

    doReset();
    runStream("R6", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1500, 8);
    runStream("R6", 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1500, 9);
    runStream("R3", 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1500, 8);
    runStream("R3", 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 3000, 32);
    runStream("R7", 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3000, 31);
    runStream("R5", 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 2000, 4);
    runStream("R5", 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 2000, 5);
    runStream("R7", 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1500, 8);
    runStream("R1", 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1200, 8);
    runStream("R2", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 800, 4);
    runStream("R8", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 800, 7);

    // R9: reset in mid-stream clears the outputs
    rstN = 1'b0;
    #1;
    check("R9", "bitValid after async reset", int'(bitValid), 0);
    check("R9", "bitOut after async reset", int'(bitOut), 0);
    rstN = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule